// File: doc/BRIEF.md
# USB Control Endpoint Zero Handler

This block is the device-side control logic for the bidirectional control endpoint (endpoint 0) of a USB function. It sits after a token and packet decoder and beside the single-buffered packet FIFO that carries endpoint 0 data. Its inputs are single-cycle strobes: decoded tokens, received data packets with their length and data PID, and the host's acknowledgement of a packet the device sent. Its outputs are a handshake code for each packet, a request to send the FIFO packet, and a request to send a zero-length packet.

Firmware drives the block through a small register port. It sees packet-ready flags, the received byte count, stall and early-end flags, and two interrupt levels. It marks a packet as loaded for sending, and it marks the last data packet of a transfer. The block follows setup, data and status stages. It answers protocol errors with a STALL. A device address register tells the rest of the chip whether endpoints other than endpoint 0 may be used.

The received-packet strobe `rx_valid`/`rx_ready` is a valid/ready pair without stall capability: the decoder presents a packet for one cycle only. If `rx_ready` is low in that cycle, the packet is refused with a NAK and the host retries later. Token and acknowledge strobes are always taken.

Top module: `usb_ep0_ctrl`

## Requirements
- R1: After reset, all four registers read 0, `irq_req`, `hs_valid`, `tx_start`, `tx_zlp` and `dev_addressed` are 0. Register indices are: 0 control/status, 1 byte count, 2 interrupt, 3 address.
- R2: A SETUP token (`tok_pid`=0) on endpoint 0 gives no handshake. The packet that follows is always taken and answered ACK (`hs_code`=0). It sets the OUT-ready bit (status bit 0) and loads its length into the byte-count register.
- R3: After an OUT token (`tok_pid`=1), a data packet of at most 32 bytes is answered ACK, sets the OUT-ready bit and loads the byte count. While OUT-ready is still set, `rx_ready` is low, and the packet gets a NAK (`hs_code`=1) with no change to any register.
- R4: An OUT data packet longer than 32 bytes is answered STALL (`hs_code`=2) and sets the sent-stall bit (status bit 2).
- R5: Writing 1 to status bit 1 marks an IN packet as loaded. An IN token (`tok_pid`=2) then raises `tx_start`, and a following `tx_ack` clears bit 1. An IN token with nothing loaded, before the data stage is closed, gets a NAK. At most one of `hs_valid`, `tx_start` and `tx_zlp` is high in any cycle.
- R6: Once firmware has set data-end (status bit 3), a further token in the direction of the data stage gets STALL and sets sent-stall. For IN this applies once the last loaded packet has been taken. A transfer with no data stage counts as OUT.
- R7: After data-end, a token in the opposite direction starts the status stage. For an IN status stage, the block raises `tx_zlp`, and the following `tx_ack` completes the transfer and clears data-end. For an OUT status stage, only a zero-length DATA1 packet (`rx_data1`=1) is answered ACK and completes the transfer; any other packet gets STALL.
- R8: A SETUP token during a data or status stage sets setup-end (status bit 4), clears the IN-ready and data-end bits, and starts a new setup stage.
- R9: Every event sets the endpoint flag (interrupt bit 0), whatever the mask says. The events are: a packet taken, a loaded packet acknowledged, a status stage completed, a STALL sent, and setup-end. The CPU flag (interrupt bit 1) is set by an event only when the endpoint mask (interrupt bit 6) is 1.
- R10: `irq_req` is high only while the CPU flag, the endpoint mask and the global enable (interrupt bit 7) are all 1.
- R11: Writing 1 clears OUT-ready, sent-stall, setup-end and both interrupt flags. When an event sets a bit in the same cycle as its clear, the bit ends up set.
- R12: The address register holds 7 bits. `dev_addressed` is 1 exactly when it is nonzero, which opens endpoints other than endpoint 0.
- R13: Tokens for a nonzero endpoint, or with `tok_pid`=3, produce no output and change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tok_valid | input | 1 | Decoded token strobe |
| tok_pid | input | 2 | Token kind: 0 SETUP, 1 OUT, 2 IN, 3 ignored |
| tok_ep | input | 4 | Endpoint number of the token |
| rx_valid | input | 1 | Received data packet strobe |
| rx_ready | output | 1 | Packet can be taken this cycle |
| rx_len | input | 7 | Received packet length in bytes |
| rx_data1 | input | 1 | Received packet carried DATA1 |
| tx_ack | input | 1 | Host acknowledged the packet the device sent |
| hs_valid | output | 1 | Handshake strobe |
| hs_code | output | 2 | 0 ACK, 1 NAK, 2 STALL |
| tx_start | output | 1 | Send the loaded FIFO packet |
| tx_zlp | output | 1 | Send a zero-length packet |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq_req | output | 1 | Interrupt request to the CPU |
| dev_addressed | output | 1 | Address is nonzero; other endpoints are enabled |

## Verification
Every result of a token, packet or acknowledge strobe comes from a register. Handshakes, send requests, status bits, byte count, both flags and `irq_req` all change on the clock edge that samples the strobe and are valid for the following cycle. Only `rx_ready` and `reg_rdata` are combinational and valid in the same cycle. The bench therefore drives each strobe just after a falling edge and reads `rx_ready` a moment later. It removes the strobe at the next falling edge and checks all registered results right there. Register writes follow the same one-edge rule, so the bench reads registers after the write strobe has dropped.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    TOK_SETUP = 2'd0,
    TOK_OUT   = 2'd1,
    TOK_IN    = 2'd2
  } tok_e;

  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2
  } hs_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_DATA,
    ST_STS_IN,
    ST_STS_OUT
  } ctl_state_e;

  // register indices
  localparam logic [1:0] RIX_CS   = 2'd0;
  localparam logic [1:0] RIX_CNT  = 2'd1;
  localparam logic [1:0] RIX_IRQ  = 2'd2;
  localparam logic [1:0] RIX_ADDR = 2'd3;

  // control/status bit positions
  localparam int CS_OUT_RDY = 0;
  localparam int CS_IN_RDY  = 1;
  localparam int CS_STALLED = 2;
  localparam int CS_DEND    = 3;
  localparam int CS_SEND    = 4;

  // interrupt register bit positions
  localparam int IQ_EPF  = 0;
  localparam int IQ_CPUF = 1;
  localparam int IQ_MASK = 6;
  localparam int IQ_GLOB = 7;

  typedef struct packed {
    logic rx_pkt;
    logic in_sent;
    logic sts_done;
    logic stall;
    logic setup_end;
  } ev_t;
endpackage

// File: rtl/ep0_xfer_fsm.sv
module ep0_xfer_fsm
  import ep0_pkg::*;
#(
  parameter int MAX_PKT = 32,
  parameter int LEN_W   = 7,
  parameter int EP_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_valid,
  input  logic [1:0]       tok_pid,
  input  logic [EP_W-1:0]  tok_ep,
  input  logic             rx_valid,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             rx_data1,
  input  logic             tx_ack,
  input  logic             out_rdy,
  input  logic             in_rdy,
  input  logic             data_end,
  output logic             rx_ready,
  output logic             hs_valid,
  output logic [1:0]       hs_code,
  output logic             tx_start,
  output logic             tx_zlp,
  output ev_t              ev,
  output logic             xfer_end,
  output logic             abort_in
);
  ctl_state_e st_q, st_d;
  logic dir_in_q, dir_in_d;
  logic lock_q, lock_d;
  logic exp_q, exp_d;
  logic hs_v_d, txs_d, zlp_d, stall;
  hs_e  hs_c_d, hs_c_q;

  logic tok0, oversize, busy;
  assign tok0     = tok_valid && (tok_ep == '0);
  assign oversize = rx_len > LEN_W'(MAX_PKT);
  assign busy     = (st_q == ST_DATA) || (st_q == ST_STS_IN) || (st_q == ST_STS_OUT);
  assign rx_ready = exp_q && !((st_q == ST_DATA) && out_rdy);

  always_comb begin
    st_d     = st_q;
    dir_in_d = dir_in_q;
    lock_d   = lock_q;
    exp_d    = exp_q;
    ev       = '0;
    xfer_end = 1'b0;
    abort_in = 1'b0;
    stall    = 1'b0;
    hs_v_d   = 1'b0;
    hs_c_d   = HS_ACK;
    txs_d    = 1'b0;
    zlp_d    = 1'b0;
    if (tok0) begin
      case (tok_pid)
        TOK_SETUP: begin
          if (busy) begin
            ev.setup_end = 1'b1;
            abort_in     = 1'b1;
          end
          st_d     = ST_SETUP;
          exp_d    = 1'b1;
          lock_d   = 1'b0;
          dir_in_d = 1'b0;
          xfer_end = 1'b1;
        end
        TOK_OUT: begin
          case (st_q)
            ST_DATA: begin
              if (dir_in_q) begin
                if (data_end && !in_rdy) begin
                  st_d  = ST_STS_OUT;
                  exp_d = 1'b1;
                end else begin
                  hs_v_d = 1'b1;
                  hs_c_d = HS_NAK;
                end
              end else if (data_end) begin
                stall = 1'b1;
              end else begin
                lock_d = 1'b1;
                exp_d  = 1'b1;
              end
            end
            ST_STS_OUT: exp_d = 1'b1;
            ST_STS_IN:  stall = 1'b1;
            default: begin
              hs_v_d = 1'b1;
              hs_c_d = HS_NAK;
            end
          endcase
        end
        TOK_IN: begin
          case (st_q)
            ST_DATA: begin
              if (dir_in_q || (!lock_q && !data_end)) begin
                lock_d   = 1'b1;
                dir_in_d = 1'b1;
                if (in_rdy) begin
                  txs_d = 1'b1;
                end else if (data_end) begin
                  stall = 1'b1;
                end else begin
                  hs_v_d = 1'b1;
                  hs_c_d = HS_NAK;
                end
              end else if (data_end) begin
                zlp_d = 1'b1;
                st_d  = ST_STS_IN;
              end else begin
                hs_v_d = 1'b1;
                hs_c_d = HS_NAK;
              end
            end
            ST_STS_IN:  zlp_d = 1'b1;
            ST_STS_OUT: stall = 1'b1;
            default: begin
              hs_v_d = 1'b1;
              hs_c_d = HS_NAK;
            end
          endcase
        end
        default: ;
      endcase
    end else if (rx_valid && exp_q) begin
      exp_d = 1'b0;
      case (st_q)
        ST_SETUP: begin
          hs_v_d    = 1'b1;
          ev.rx_pkt = 1'b1;
          st_d      = ST_DATA;
        end
        ST_DATA: begin
          if (out_rdy) begin
            hs_v_d = 1'b1;
            hs_c_d = HS_NAK;
          end else if (oversize) begin
            stall = 1'b1;
          end else begin
            hs_v_d    = 1'b1;
            ev.rx_pkt = 1'b1;
          end
        end
        ST_STS_OUT: begin
          if ((rx_len == '0) && rx_data1) begin
            hs_v_d      = 1'b1;
            ev.sts_done = 1'b1;
            st_d        = ST_IDLE;
            xfer_end    = 1'b1;
          end else begin
            stall = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (tx_ack) begin
      if ((st_q == ST_DATA) && dir_in_q && in_rdy) begin
        ev.in_sent = 1'b1;
      end else if (st_q == ST_STS_IN) begin
        ev.sts_done = 1'b1;
        st_d        = ST_IDLE;
        xfer_end    = 1'b1;
      end
    end
    if (stall) begin
      hs_v_d   = 1'b1;
      hs_c_d   = HS_STALL;
      ev.stall = 1'b1;
      st_d     = ST_IDLE;
      exp_d    = 1'b0;
      lock_d   = 1'b0;
      dir_in_d = 1'b0;
      xfer_end = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      dir_in_q <= 1'b0;
      lock_q   <= 1'b0;
      exp_q    <= 1'b0;
      hs_valid <= 1'b0;
      hs_c_q   <= HS_ACK;
      tx_start <= 1'b0;
      tx_zlp   <= 1'b0;
    end else begin
      st_q     <= st_d;
      dir_in_q <= dir_in_d;
      lock_q   <= lock_d;
      exp_q    <= exp_d;
      hs_valid <= hs_v_d;
      hs_c_q   <= hs_c_d;
      tx_start <= txs_d;
      tx_zlp   <= zlp_d;
    end
  end

  assign hs_code = hs_c_q;
endmodule

// File: rtl/ep0_csr.sv
module ep0_csr
  import ep0_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cs,
  input  logic              wr_addr,
  input  logic [ADDR_W-1:0] wdata,
  input  ev_t               ev,
  input  logic              xfer_end,
  input  logic              abort_in,
  input  logic [CNT_W-1:0]  rx_cnt,
  output logic              out_rdy,
  output logic              in_rdy,
  output logic              sent_stall,
  output logic              data_end,
  output logic              setup_end,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic [ADDR_W-1:0] dev_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_rdy    <= 1'b0;
      in_rdy     <= 1'b0;
      sent_stall <= 1'b0;
      data_end   <= 1'b0;
      setup_end  <= 1'b0;
      byte_cnt   <= '0;
      dev_addr   <= '0;
    end else begin
      // hardware events win over firmware clears
      if (ev.rx_pkt)                        out_rdy <= 1'b1;
      else if (wr_cs && wdata[CS_OUT_RDY])  out_rdy <= 1'b0;

      if (ev.in_sent || abort_in)           in_rdy <= 1'b0;
      else if (wr_cs && wdata[CS_IN_RDY])   in_rdy <= 1'b1;

      if (ev.stall)                         sent_stall <= 1'b1;
      else if (wr_cs && wdata[CS_STALLED])  sent_stall <= 1'b0;

      if (xfer_end)                         data_end <= 1'b0;
      else if (wr_cs && wdata[CS_DEND])     data_end <= 1'b1;

      if (ev.setup_end)                     setup_end <= 1'b1;
      else if (wr_cs && wdata[CS_SEND])     setup_end <= 1'b0;

      if (ev.rx_pkt)                        byte_cnt <= rx_cnt;
      if (wr_addr)                          dev_addr <= wdata;
    end
  end
endmodule

// File: rtl/ep0_irq.sv
module ep0_irq
  import ep0_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ev_t  ev,
  input  logic wr_irq,
  input  logic clr_ep,
  input  logic clr_cpu,
  input  logic new_mask,
  input  logic new_glob,
  output logic ep_flag,
  output logic cpu_flag,
  output logic ep_mask,
  output logic glob_en,
  output logic irq_req
);
  logic ev_any;
  assign ev_any = |ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ep_flag  <= 1'b0;
      cpu_flag <= 1'b0;
      ep_mask  <= 1'b0;
      glob_en  <= 1'b0;
    end else begin
      if (ev_any)                 ep_flag <= 1'b1;
      else if (wr_irq && clr_ep)  ep_flag <= 1'b0;

      if (ev_any && ep_mask)      cpu_flag <= 1'b1;
      else if (wr_irq && clr_cpu) cpu_flag <= 1'b0;

      if (wr_irq) begin
        ep_mask <= new_mask;
        glob_en <= new_glob;
      end
    end
  end

  assign irq_req = cpu_flag && ep_mask && glob_en;
endmodule

// File: rtl/usb_ep0_ctrl.sv
module usb_ep0_ctrl
  import ep0_pkg::*;
#(
  parameter int MAX_PKT = 32,
  parameter int LEN_W   = 7,
  parameter int EP_W    = 4,
  parameter int ADDR_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_valid,
  input  logic [1:0]       tok_pid,
  input  logic [EP_W-1:0]  tok_ep,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             rx_data1,
  input  logic             tx_ack,
  output logic             hs_valid,
  output logic [1:0]       hs_code,
  output logic             tx_start,
  output logic             tx_zlp,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_req,
  output logic             dev_addressed
);
  localparam int CNT_W = $clog2(MAX_PKT + 1);

  ev_t ev;
  logic xfer_end, abort_in;
  logic out_rdy, in_rdy, sent_stall, data_end, setup_end;
  logic ep_flag, cpu_flag, ep_mask, glob_en;
  logic [CNT_W-1:0]  byte_cnt;
  logic [ADDR_W-1:0] dev_addr;
  logic wr_cs, wr_irq, wr_adr;

  assign wr_cs  = reg_wr && (reg_addr == RIX_CS);
  assign wr_irq = reg_wr && (reg_addr == RIX_IRQ);
  assign wr_adr = reg_wr && (reg_addr == RIX_ADDR);

  ep0_xfer_fsm #(.MAX_PKT(MAX_PKT), .LEN_W(LEN_W), .EP_W(EP_W)) i_fsm (
    .clk(clk), .rst_n(rst_n),
    .tok_valid(tok_valid), .tok_pid(tok_pid), .tok_ep(tok_ep),
    .rx_valid(rx_valid), .rx_len(rx_len), .rx_data1(rx_data1),
    .tx_ack(tx_ack), .out_rdy(out_rdy), .in_rdy(in_rdy), .data_end(data_end),
    .rx_ready(rx_ready), .hs_valid(hs_valid), .hs_code(hs_code),
    .tx_start(tx_start), .tx_zlp(tx_zlp), .ev(ev),
    .xfer_end(xfer_end), .abort_in(abort_in)
  );

  ep0_csr #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_csr (
    .clk(clk), .rst_n(rst_n),
    .wr_cs(wr_cs), .wr_addr(wr_adr), .wdata(reg_wdata[ADDR_W-1:0]),
    .ev(ev), .xfer_end(xfer_end), .abort_in(abort_in),
    .rx_cnt(rx_len[CNT_W-1:0]),
    .out_rdy(out_rdy), .in_rdy(in_rdy), .sent_stall(sent_stall),
    .data_end(data_end), .setup_end(setup_end),
    .byte_cnt(byte_cnt), .dev_addr(dev_addr)
  );

  ep0_irq i_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev), .wr_irq(wr_irq),
    .clr_ep(reg_wdata[IQ_EPF]), .clr_cpu(reg_wdata[IQ_CPUF]),
    .new_mask(reg_wdata[IQ_MASK]), .new_glob(reg_wdata[IQ_GLOB]),
    .ep_flag(ep_flag), .cpu_flag(cpu_flag), .ep_mask(ep_mask),
    .glob_en(glob_en), .irq_req(irq_req)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RIX_CS: begin
        reg_rdata[CS_OUT_RDY] = out_rdy;
        reg_rdata[CS_IN_RDY]  = in_rdy;
        reg_rdata[CS_STALLED] = sent_stall;
        reg_rdata[CS_DEND]    = data_end;
        reg_rdata[CS_SEND]    = setup_end;
      end
      RIX_CNT: reg_rdata = REG_W'(byte_cnt);
      RIX_IRQ: begin
        reg_rdata[IQ_EPF]  = ep_flag;
        reg_rdata[IQ_CPUF] = cpu_flag;
        reg_rdata[IQ_MASK] = ep_mask;
        reg_rdata[IQ_GLOB] = glob_en;
      end
      default: reg_rdata = REG_W'(dev_addr);
    endcase
  end

  assign dev_addressed = (dev_addr != '0);
endmodule

// File: rtl/ep0_ctrl_chk.sv
module ep0_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hs_valid,
  input logic [1:0] hs_code,
  input logic       tx_start,
  input logic       tx_zlp,
  input logic       sent_stall,
  input logic       ep_flag,
  input logic       cpu_flag,
  input logic       ep_mask,
  input logic       in_rdy,
  input logic       tx_ack,
  input logic       tok_valid
);
  AST_STALL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_code == 2'd2) |-> (sent_stall && ep_flag)); // R6
  AST_CPU_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_flag) |-> $past(ep_mask)); // R9
  AST_SINGLE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hs_valid, tx_start, tx_zlp})); // R5
  AST_INRDY_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_rdy) |-> $past(tx_ack || tok_valid)); // R5
endmodule

bind usb_ep0_ctrl ep0_ctrl_chk i_ep0_chk (
  .clk(clk), .rst_n(rst_n), .hs_valid(hs_valid), .hs_code(hs_code),
  .tx_start(tx_start), .tx_zlp(tx_zlp), .sent_stall(sent_stall),
  .ep_flag(ep_flag), .cpu_flag(cpu_flag), .ep_mask(ep_mask),
  .in_rdy(in_rdy), .tx_ack(tx_ack), .tok_valid(tok_valid)
);

// File: tb/test_usb_ep0_ctrl.sv
module test_usb_ep0_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_valid = 0, rx_valid = 0, rx_data1 = 0, tx_ack = 0, reg_wr = 0;
  logic [1:0] tok_pid = 0, reg_addr = 0;
  logic [3:0] tok_ep = 0;
  logic [6:0] rx_len = 0;
  logic [7:0] reg_wdata = 0;
  logic rx_ready, hs_valid, tx_start, tx_zlp, irq_req, dev_addressed;
  logic [1:0] hs_code;
  logic [7:0] reg_rdata;

  usb_ep0_ctrl i_usb_ep0_ctrl (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_pid(tok_pid), .tok_ep(tok_ep),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_len(rx_len), .rx_data1(rx_data1),
    .tx_ack(tx_ack), .hs_valid(hs_valid), .hs_code(hs_code), .tx_start(tx_start),
    .tx_zlp(tx_zlp), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .dev_addressed(dev_addressed)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic c_hs, c_txs, c_zlp, c_rdy;
  logic [1:0] c_code;
  // bench model of the register state
  bit m_out, m_in, m_stall, m_dend, m_send, m_epf, m_cpuf, m_mask, m_glob;
  int m_cnt;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pack_cs();
    return {m_send, m_dend, m_stall, m_in, m_out};
  endfunction
  function automatic int pack_irq();
    return {m_glob, m_mask, 4'b0, m_cpuf, m_epf};
  endfunction
  function automatic void ev_fire();
    m_epf = 1;
    if (m_mask) m_cpuf = 1;
  endfunction
  function automatic void ev_stall();
    m_stall = 1; m_dend = 0; ev_fire();
  endfunction

  task automatic capture();
    c_hs = hs_valid; c_code = hs_code; c_txs = tx_start; c_zlp = tx_zlp;
  endtask

  task automatic drive_tok(input logic [1:0] pid, input logic [3:0] ep);
    @(negedge clk); tok_valid = 1; tok_pid = pid; tok_ep = ep;
    @(negedge clk); tok_valid = 0; capture();
  endtask

  task automatic drive_rx(input int len, input bit d1);
    @(negedge clk); rx_valid = 1; rx_len = 7'(len); rx_data1 = d1;
    #1 c_rdy = rx_ready;
    @(negedge clk); rx_valid = 0; capture();
  endtask

  task automatic drive_ack();
    @(negedge clk); tx_ack = 1;
    @(negedge clk); tx_ack = 0; capture();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    reg_addr = a; #1 d = int'(reg_rdata);
  endtask

  task automatic fw_cs(input logic [7:0] w);
    if (w[0]) m_out = 0;
    if (w[1]) m_in = 1;
    if (w[2]) m_stall = 0;
    if (w[3]) m_dend = 1;
    if (w[4]) m_send = 0;
    wr(2'd0, w);
  endtask

  task automatic fw_irq(input bit mask, input bit glob, input bit clr);
    m_mask = mask; m_glob = glob;
    if (clr) begin m_epf = 0; m_cpuf = 0; end
    wr(2'd2, {glob, mask, 4'b0, clr, clr});
  endtask

  task automatic expect_hs(input string req, input bit v, input int code);
    chk({req, " hs_valid"}, c_hs, v);
    if (v) chk({req, " hs_code"}, c_code, code);
  endtask

  task automatic chk_regs(input string req);
    int d;
    rd(2'd0, d); chk({req, " status"}, d, pack_cs());
    rd(2'd1, d); chk({req, " count"}, d, m_cnt);
    rd(2'd2, d); chk({req, " irq reg"}, d, pack_irq());
    chk({req, " irq_req"}, irq_req, m_cpuf && m_mask && m_glob);
  endtask

  task automatic do_setup();
    drive_tok(2'd0, 4'd0);
    m_dend = 0;
    expect_hs("R2 setup token", 0, 0);
    drive_rx(8, 0);
    chk("R2 setup ready", c_rdy, 1);
    expect_hs("R2 setup pkt", 1, 0);
    m_out = 1; m_cnt = 8; ev_fire();
    chk_regs("R2");
    fw_cs(8'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int d, len, seed;
    bit in_xfer;
    seed = $urandom(32'h5eed_0e0f);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_regs("R1");
    rd(2'd3, d); chk("R1 address", d, 0);
    chk("R1 hs_valid", hs_valid, 0);
    chk("R1 tx", tx_start | tx_zlp, 0);
    chk("R1 dev_addressed", dev_addressed, 0);

    // R2 setup, flags with mask clear (R9, R10)
    do_setup();
    fw_irq(0, 0, 1);

    // R3/R4 random OUT data stage traffic with random masks
    in_xfer = 1;
    for (int i = 0; i < 24; i++) begin
      if (!in_xfer) begin do_setup(); in_xfer = 1; end
      len = $urandom % 41;
      drive_tok(2'd1, 4'd0);
      expect_hs("R3 out token", 0, 0);
      drive_rx(len, i[0]);
      chk("R3 ready", c_rdy, 1);
      if (len > 32) begin
        expect_hs("R4 oversize", 1, 2);
        ev_stall(); in_xfer = 0;
      end else begin
        expect_hs("R3 accept", 1, 0);
        m_out = 1; m_cnt = len; ev_fire();
        if (i % 3 == 0) begin
          drive_tok(2'd1, 4'd0);
          drive_rx(5, 0);
          chk("R3 busy ready", c_rdy, 0);
          expect_hs("R3 busy nak", 1, 1);
        end
      end
      chk_regs("R3 R4 R9 R10");
      fw_cs(8'h05);
      fw_irq($urandom % 2, $urandom % 2, $urandom % 2);
      chk_regs("R11 R10");
    end
    if (!in_xfer) do_setup();

    // R6 with same-cycle clear of sent-stall (R11)
    fw_irq(1, 1, 1);
    fw_cs(8'h08);
    @(negedge clk);
    tok_valid = 1; tok_pid = 2'd1; tok_ep = 0;
    reg_wr = 1; reg_addr = 2'd0; reg_wdata = 8'h04;
    @(negedge clk);
    tok_valid = 0; reg_wr = 0; capture();
    expect_hs("R6 out after data-end", 1, 2);
    ev_stall();
    chk_regs("R6 R11 priority");
    fw_cs(8'h04);
    fw_irq(1, 1, 1);
    chk_regs("R11 clear");

    // R7 status IN after no-data transfer
    do_setup();
    fw_cs(8'h08);
    drive_tok(2'd2, 4'd0);
    chk("R7 zlp", c_zlp, 1);
    expect_hs("R7 zlp no hs", 0, 0);
    drive_ack();
    m_dend = 0; ev_fire();
    chk_regs("R7 status in done");
    fw_irq(0, 1, 1);

    // R5 IN data stage, R6 for IN
    do_setup();
    drive_tok(2'd2, 4'd0);
    expect_hs("R5 empty nak", 1, 1);
    fw_cs(8'h02);
    drive_tok(2'd2, 4'd0);
    chk("R5 tx_start", c_txs, 1);
    drive_ack();
    m_in = 0; ev_fire();
    chk_regs("R5 sent");
    fw_cs(8'h0A);
    drive_tok(2'd2, 4'd0);
    chk("R5 last tx_start", c_txs, 1);
    drive_ack();
    m_in = 0; ev_fire();
    drive_tok(2'd2, 4'd0);
    expect_hs("R6 in after data-end", 1, 2);
    ev_stall();
    chk_regs("R6 in");
    fw_cs(8'h04);
    fw_irq(1, 0, 1);

    // R7 status OUT stage checks
    for (int k = 0; k < 3; k++) begin
      do_setup();
      fw_cs(8'h02);
      drive_tok(2'd2, 4'd0);
      chk("R5 tx_start", c_txs, 1);
      drive_ack();
      m_in = 0; ev_fire();
      fw_cs(8'h08);
      drive_tok(2'd1, 4'd0);
      expect_hs("R7 status token", 0, 0);
      if (k == 0) begin
        drive_rx(0, 0);
        expect_hs("R7 data0 status", 1, 2);
        ev_stall();
      end else if (k == 1) begin
        drive_rx(1 + $urandom % 32, 1);
        expect_hs("R7 nonzero status", 1, 2);
        ev_stall();
      end else begin
        drive_rx(0, 1);
        expect_hs("R7 good status", 1, 0);
        m_dend = 0; ev_fire();
      end
      chk_regs("R7 status out");
      fw_cs(8'h04);
    end

    // R8 setup during data stage
    fw_irq(1, 1, 1);
    do_setup();
    fw_cs(8'h02);
    drive_tok(2'd1, 4'd0);
    drive_rx(4, 1);
    expect_hs("R3 accept", 1, 0);
    m_out = 1; m_cnt = 4; ev_fire();
    drive_tok(2'd0, 4'd0);
    expect_hs("R8 setup token", 0, 0);
    m_send = 1; m_in = 0; m_dend = 0; ev_fire();
    chk_regs("R8 setup end");
    drive_rx(8, 0);
    chk("R8 restart ready", c_rdy, 1);
    expect_hs("R8 restart ack", 1, 0);
    m_cnt = 8; ev_fire();
    fw_cs(8'h11);
    chk_regs("R8 R11");
    fw_irq(0, 0, 1);

    // R13 tokens ignored
    drive_tok(2'd1, 4'd5);
    expect_hs("R13 other ep", 0, 0);
    drive_tok(2'd3, 4'd0);
    expect_hs("R13 pid3", 0, 0);
    drive_tok(2'd2, 4'd3);
    chk("R13 no tx", c_txs | c_zlp, 0);
    chk_regs("R13");

    // R12 address
    len = 1 + $urandom % 127;
    wr(2'd3, 8'(len));
    rd(2'd3, d); chk("R12 address", d, len);
    chk("R12 addressed", dev_addressed, 1);
    wr(2'd3, 8'h80);
    rd(2'd3, d); chk("R12 address zero", d, 0);
    chk("R12 default", dev_addressed, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule